// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. It places a trial code on a DAC code output. It reads a one-bit comparator answer that says whether the trial code lies above the sampled input. It then settles the conversion one bit per converter clock, starting from the most significant bit. The analog array, the comparator and the input multiplexer sit outside the block. The block drives the multiplexer channel select and a sample-phase output for them, and it keeps one result register per input channel.

Software reaches the block through a small register port. The first control register sets the converter clock divider, the sampling length and the resolution (8 or 10 bits). Writing it halts the converter. The second control register picks the channel group, the group size (4 or 8 channels) and single or continuous operation. Writing it aborts any sequence in progress and starts a fresh one with the written settings. A status register reports per-channel completion, the channel being converted, whether a sequence is active, and whether a whole sequence has finished.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A bit trial clears the trial bit when `cmpHigh` is 1 (trial code above input) and keeps it otherwise. The stored result therefore equals the channel's input level, saturated at full scale (1023 at 10 bits, 255 at 8 bits).
- R2: The bit trials run from the most significant bit downward, one per converter clock. At the end of sampling, `dacCode` holds only the top bit (0x200 at 10 bits, 0x080 at 8 bits). Each later converter clock settles one bit and sets the next lower bit.
- R3: Each conversion begins with a sample phase in which `sampleOut` is 1 and `chanSel` is held. Its length is 2, 4, 8 or 16 converter clocks for sample code 0, 1, 2 or 3 in control register 0 bits [6:5].
- R4: One converter clock lasts 2*max(P+1, 2) system clocks, where P is control register 0 bits [4:0]. The divider restarts when a sequence starts.
- R5: A write to control register 0 (write address 0) leaves the converter halted on the next cycle (status bit 11 = 0, `sampleOut` = 0). No result register or completion flag changes after that.
- R6: A write to control register 1 (write address 1) aborts the sequence in progress, clears all completion flags and the sequence-complete flag, and starts a new sequence on the next cycle.
- R7: Control register 1 bit 1 = 1 converts channels 0 to 7 in order. Bit 1 = 0 converts 4 channels in order: channels 0 to 3 when bit 0 = 0, channels 4 to 7 when bit 0 = 1. Each result goes to the result register of its own channel, and registers outside the group keep their values.
- R8: With control register 1 bit 2 = 0 (single mode), the converter returns to idle after the last channel of the group and sets the sequence-complete flag.
- R9: With control register 1 bit 2 = 1 (continuous mode), the sequence restarts at the first channel of the group after the last one. Results keep being refreshed until control register 0 is written.
- R10: Control register 0 bit 7 = 1 selects 10-bit resolution and 0 selects 8-bit. An 8-bit result is right-justified in the 10-bit result, with bits [9:8] zero.
- R11: Reads are combinational. Read address 0 returns control register 0, 1 returns control register 1 (bits [2:0]), and 2 returns status. Addresses 8+n return the result of channel n. Status bits [7:0] are the per-channel completion flags, [10:8] the current channel, [11] sequence active, and [12] sequence complete.
- R12: After reset every register reads zero, the converter is idle, and `dacCode` and `sampleOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control 0, 1 control 1, others ignored |
| wrData | input | 8 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 16 | Read data for `rdAddr` |
| cmpHigh | input | 1 | Comparator: 1 when the trial code is above the sampled input |
| dacCode | output | 10 | Trial code to the DAC array |
| chanSel | output | 3 | Analog multiplexer channel select |
| sampleOut | output | 1 | High during the sample phase |

## Verification
On every cycle the assertions check four things. A control register 0 write halts the converter and a control register 1 write starts sampling. The channel select holds still between conversion ends, and a single-mode sequence ends in idle. They also check that loading the first trial leaves exactly one bit set, that an 8-bit result carries zero upper bits, and that a start clears the flags. Only the bench scenarios can show that the results match the behavioural comparator's input levels. The same holds for the sample length in system clocks under different divider settings, the group ordering, result registers left alone outside the group, continuous refresh, and the absence of any update after an abort.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } sarState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;   // new sequence: flags and trial register cleared
    logic loadTrial;  // put the top trial bit on the DAC
    logic resolve;    // settle the current trial bit
    logic store;      // last bit of a conversion: write the result
    logic seqEnd;     // last conversion of the group
  } sarStrobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int RES_MAX = 10,
  parameter int PRS_W   = 5,
  localparam int CH_W   = $clog2(N_CH),
  localparam int BIT_W  = $clog2(RES_MAX),
  localparam int RES_MIN = RES_MAX - 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [7:0]       wrData,
  output sarStrobe_t       strobe,
  output logic [BIT_W-1:0] bitIdx,
  output logic [BIT_W-1:0] msbIdx,
  output logic [CH_W-1:0]  chanSel,
  output logic             active,
  output logic             sampleOut,
  output logic [PRS_W-1:0] prs,
  output logic [1:0]       stCode,
  output logic             res10,
  output logic             grpHi,
  output logic             wide,
  output logic             cont
);

  sarState_t state;
  logic wr0, wr1, wrAny;
  logic [PRS_W:0]   firstDiv;
  logic [PRS_W+1:0] period, divCnt;
  logic [4:0]       sampleClocks, sampCnt;
  logic [CH_W-1:0]  convIdx, lastIdx, baseCh;
  logic tick, tickEff, sampleLast;

  assign wr0   = wrEn && (wrAddr == 2'd0);
  assign wr1   = wrEn && (wrAddr == 2'd1);
  assign wrAny = wr0 || wr1;

  // Two-stage prescaler: modulus stage (minimum 2) then divide by two
  assign firstDiv = (prs == '0) ? (PRS_W+1)'(2) : ({1'b0, prs} + (PRS_W+1)'(1));
  assign period   = {firstDiv, 1'b0};
  assign tick     = (state != ST_IDLE) && (divCnt == period - (PRS_W+2)'(1));
  assign tickEff  = tick && !wrAny;

  always_ff @(posedge clk) begin
    if (!rstN || wr1 || state == ST_IDLE || tick) divCnt <= '0;
    else                                          divCnt <= divCnt + (PRS_W+2)'(1);
  end

  assign sampleClocks = 5'd2 << stCode;
  assign sampleLast   = (sampCnt == sampleClocks - 5'd1);
  assign lastIdx      = wide ? CH_W'(N_CH - 1) : CH_W'(N_CH / 2 - 1);
  assign baseCh       = grpHi ? CH_W'(N_CH / 2) : '0;
  assign chanSel      = wide ? convIdx : (baseCh + convIdx);
  assign msbIdx       = res10 ? BIT_W'(RES_MAX - 1) : BIT_W'(RES_MIN - 1);
  assign active       = (state != ST_IDLE);
  assign sampleOut    = (state == ST_SAMPLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; prs <= '0; stCode <= '0; res10 <= 1'b0;
      grpHi <= 1'b0; wide <= 1'b0; cont <= 1'b0;
      sampCnt <= '0; convIdx <= '0; bitIdx <= '0;
    end else if (wr0) begin
      state  <= ST_IDLE;
      prs    <= wrData[PRS_W-1:0];
      stCode <= wrData[6:5];
      res10  <= wrData[7];
    end else if (wr1) begin
      grpHi   <= wrData[0];
      wide    <= wrData[1];
      cont    <= wrData[2];
      state   <= ST_SAMPLE;
      sampCnt <= '0;
      convIdx <= '0;
    end else if (tick) begin
      case (state)
        ST_SAMPLE: begin
          if (sampleLast) begin
            state  <= ST_CONVERT;
            bitIdx <= msbIdx;
          end else begin
            sampCnt <= sampCnt + 5'd1;
          end
        end
        ST_CONVERT: begin
          if (bitIdx == '0) begin
            sampCnt <= '0;
            if (convIdx == lastIdx) begin
              convIdx <= '0;
              state   <= cont ? ST_SAMPLE : ST_IDLE;
            end else begin
              convIdx <= convIdx + CH_W'(1);
              state   <= ST_SAMPLE;
            end
          end else begin
            bitIdx <= bitIdx - BIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.clearAll  = wr1;
    strobe.loadTrial = tickEff && (state == ST_SAMPLE) && sampleLast;
    strobe.resolve   = tickEff && (state == ST_CONVERT);
    strobe.store     = strobe.resolve && (bitIdx == '0);
    strobe.seqEnd    = strobe.store && (convIdx == lastIdx);
  end

  // R5: a write to control 0 halts the converter
  p_ctl0_halts_r5: assert property (@(posedge clk) disable iff (!rstN)
    wr0 |=> (!active && !sampleOut));

  // R6: a write to control 1 starts a new sequence in the sample phase
  p_ctl1_starts_r6: assert property (@(posedge clk) disable iff (!rstN)
    wr1 |=> (active && sampleOut));

  // R3: channel select only moves at the end of a conversion
  p_chan_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (active && !wrAny && !strobe.store) |=> $stable(chanSel));

  // R8: single mode returns to idle after the last channel
  p_single_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.seqEnd && !cont && !wrAny) |=> !active);

endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int RES_MAX = 10,
  localparam int CH_W   = $clog2(N_CH),
  localparam int BIT_W  = $clog2(RES_MAX),
  localparam int RES_MIN = RES_MAX - 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sarStrobe_t                strobe,
  input  logic [BIT_W-1:0]          bitIdx,
  input  logic [BIT_W-1:0]          msbIdx,
  input  logic [CH_W-1:0]           chanSel,
  input  logic                      cmpHigh,
  input  logic                      res10,
  output logic [RES_MAX-1:0]        dacCode,
  output logic [N_CH*RES_MAX-1:0]   resultFlat,
  output logic [N_CH-1:0]           doneFlags,
  output logic                      seqDone
);

  localparam logic [RES_MAX-1:0] ONE = RES_MAX'(1);

  logic [RES_MAX-1:0] sar, nextSar, trialMask, lowerMask;
  logic [RES_MAX-1:0] results [N_CH];

  assign trialMask = ONE << bitIdx;
  assign lowerMask = trialMask >> 1;
  assign nextSar   = (sar & ~(cmpHigh ? trialMask : '0)) | lowerMask;
  assign dacCode   = sar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sar <= '0; doneFlags <= '0; seqDone <= 1'b0;
      for (int i = 0; i < N_CH; i++) results[i] <= '0;
    end else if (strobe.clearAll) begin
      sar <= '0; doneFlags <= '0; seqDone <= 1'b0;
    end else begin
      if (strobe.loadTrial) sar <= ONE << msbIdx;
      else if (strobe.resolve) sar <= nextSar;
      if (strobe.store) begin
        results[chanSel]   <= nextSar;
        doneFlags[chanSel] <= 1'b1;
      end
      if (strobe.seqEnd) seqDone <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_flat
    assign resultFlat[g*RES_MAX +: RES_MAX] = results[g];
  end

  // R2: the first trial is a single bit
  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTrial |=> ($countones(dacCode) == 1));

  // R10: 8-bit results carry zero upper bits
  p_justify_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.store && !res10) |-> (nextSar[RES_MAX-1:RES_MIN] == '0));

  // R6: a new sequence clears the completion flags
  p_flags_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (doneFlags == '0 && !seqDone));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int N_CH    = 8,
  parameter int RES_MAX = 10,
  parameter int PRS_W   = 5,
  localparam int CH_W   = $clog2(N_CH),
  localparam int BIT_W  = $clog2(RES_MAX),
  localparam int RD_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [7:0]         wrData,
  input  logic [CH_W:0]      rdAddr,
  output logic [RD_W-1:0]    rdData,
  input  logic               cmpHigh,
  output logic [RES_MAX-1:0] dacCode,
  output logic [CH_W-1:0]    chanSel,
  output logic               sampleOut
);

  sarStrobe_t strobe;
  logic [BIT_W-1:0] bitIdx, msbIdx;
  logic active, res10, grpHi, wide, cont, seqDone;
  logic [PRS_W-1:0] prs;
  logic [1:0] stCode;
  logic [N_CH-1:0] doneFlags;
  logic [N_CH*RES_MAX-1:0] resultFlat;

  sar_ctrl #(.N_CH(N_CH), .RES_MAX(RES_MAX), .PRS_W(PRS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .bitIdx(bitIdx), .msbIdx(msbIdx), .chanSel(chanSel),
    .active(active), .sampleOut(sampleOut), .prs(prs), .stCode(stCode),
    .res10(res10), .grpHi(grpHi), .wide(wide), .cont(cont)
  );

  sar_dpath #(.N_CH(N_CH), .RES_MAX(RES_MAX)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx), .msbIdx(msbIdx),
    .chanSel(chanSel), .cmpHigh(cmpHigh), .res10(res10), .dacCode(dacCode),
    .resultFlat(resultFlat), .doneFlags(doneFlags), .seqDone(seqDone)
  );

  always_comb begin
    rdData = '0;
    if (rdAddr[CH_W]) begin
      rdData = RD_W'(resultFlat[rdAddr[CH_W-1:0]*RES_MAX +: RES_MAX]);
    end else begin
      case (rdAddr[1:0])
        2'd0:    rdData = RD_W'({res10, stCode, prs});
        2'd1:    rdData = RD_W'({cont, wide, grpHi});
        2'd2:    rdData = RD_W'({seqDone, active, chanSel, doneFlags});
        default: rdData = '0;
      endcase
    end
  end

endmodule

// File: tb/sim_sar_conv_ctrl.sv
module sim_sar_conv_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdAddr = '0;
  logic [15:0] rdData;
  logic cmpHigh, sampleOut;
  logic [9:0] dacCode;
  logic [2:0] chanSel;
  logic [9:0] vin [8];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural comparator
  assign cmpHigh = dacCode > vin[chanSel];

  sar_conv_ctrl u0 (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cmpHigh(cmpHigh), .dacCode(dacCode),
    .chanSel(chanSel), .sampleOut(sampleOut));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rdAddr = a; #1 d = rdData;
  endtask

  task automatic waitIdle(input int maxc);
    logic [15:0] s;
    for (int i = 0; i < maxc; i++) begin
      rd(4'd2, s);
      if (!s[11]) break;
      @(negedge clk);
    end
  endtask

  task automatic tReset;
    logic [15:0] d;
    rd(4'd2, d); check("R12 status", d, 0);
    rd(4'd0, d); check("R12 ctl0", d, 0);
    rd(4'd9, d); check("R12 result1", d, 0);
    check("R12 dac", dacCode, 0);
    check("R12 sample", sampleOut, 0);
  endtask

  task automatic tSingleWide;
    logic [15:0] d;
    vin[0] = 0; vin[1] = 1; vin[2] = 512; vin[3] = 1023;
    vin[4] = 300; vin[5] = 77; vin[6] = 700; vin[7] = 1000;
    wr(2'd0, 8'h80);
    rd(4'd0, d); check("R11 ctl0 readback", d, 8'h80);
    wr(2'd1, 8'h02);
    waitIdle(2000);
    for (int c = 0; c < 8; c++) begin
      rd(4'(8 + c), d); check("R1 R7 wide result", d, vin[c]);
    end
    rd(4'd2, d);
    check("R8 R11 done flags", d[7:0], 8'hFF);
    check("R8 seq complete", d[12], 1);
    check("R8 idle", d[11], 0);
  endtask

  task automatic tGroupHigh8;
    logic [15:0] d;
    vin[4] = 255; vin[5] = 256; vin[6] = 1000; vin[7] = 18;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    rd(4'd2, d); check("R6 flags cleared", d[7:0], 0);
    waitIdle(2000);
    check("R10 ch4", 0, 0);
    rd(4'd12, d); check("R10 result4", d, 255);
    rd(4'd13, d); check("R10 saturate result5", d, 255);
    rd(4'd14, d); check("R10 saturate result6", d, 255);
    rd(4'd15, d); check("R1 result7", d, 18);
    rd(4'd8, d);  check("R7 result0 kept", d, 0);
    rd(4'd11, d); check("R7 result3 kept", d, 1023);
    rd(4'd2, d);  check("R7 group flags", d[7:0], 8'hF0);
    check("R8 single seq complete", d[12], 1);
  endtask

  task automatic measureSample(input logic [7:0] c0, input int exp, input string req);
    int n = 0;
    wr(2'd0, c0);
    wr(2'd1, 8'h00);
    while (sampleOut && n < 1000) begin n++; @(negedge clk); end
    check(req, n, exp);
  endtask

  task automatic tSampleTime;
    measureSample(8'h63, 128, "R3 R4 sample prs3 st3");
    wr(2'd0, 8'h00);
    measureSample(8'h20, 16, "R3 sample prs0 st1");
    wr(2'd0, 8'h00);
    measureSample(8'h01, 8, "R4 sample prs1 st0");
    check("R2 first trial 8-bit", dacCode, 10'h080);
    repeat (4) @(negedge clk);
    check("R2 second trial", dacCode, 10'h040);
    wr(2'd0, 8'h01);
  endtask

  task automatic tAbort;
    logic [15:0] d;
    wr(2'd0, 8'h80);
    vin[1] = 900;
    wr(2'd1, 8'h02);
    repeat (59) @(negedge clk);
    rd(4'd2, d);
    check("R11 current channel", d[10:8], 1);
    check("R11 active", d[11], 1);
    wr(2'd0, 8'h80);
    rd(4'd2, d); check("R5 halted", d[11], 0);
    check("R5 sample low", sampleOut, 0);
    repeat (400) @(negedge clk);
    rd(4'd2, d); check("R5 flags frozen", d[7:0], 8'h01);
    rd(4'd9, d); check("R5 result1 unchanged", d, 1);
  endtask

  task automatic tContinuous;
    logic [15:0] d;
    vin[1] = 600;
    wr(2'd1, 8'h04);
    repeat (250) @(negedge clk);
    rd(4'd2, d);
    check("R9 seq complete", d[12], 1);
    check("R9 still active", d[11], 1);
    rd(4'd9, d); check("R9 result1", d, 600);
    vin[1] = 333;
    repeat (420) @(negedge clk);
    rd(4'd9, d); check("R9 refreshed result1", d, 333);
    wr(2'd0, 8'h80);
    rd(4'd2, d); check("R5 stop continuous", d[11], 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tSingleWide;
    tGroupHigh8;
    tSampleTime;
    tAbort;
    tContinuous;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule